// File: doc/BRIEF.md
# Post-Configuration Startup Sequencer

This block brings a programmable logic device out of configuration in an orderly way. Once a start request is seen, a three-bit phase counter walks from phase 0 towards phase 7, one step per clock. Four chip-wide controls change state as it goes. DONE rises. The global 3-state hold on the I/O buffers is released. The global write enable is granted, which also lets block RAM be read and written. The global set-reset is released. Each control has its own 4-bit setting. The setting either ties the change to a phase or, for the three global controls, makes it wait for the DONE-in level or leaves the control untouched.

Two stall points can hold the counter at a chosen phase. One waits for a clock-manager lock input and the other for an impedance-match input. The current phase and one flag per stall point are visible at the ports. A start request given after the sequence finishes runs it again for a partial reconfiguration. Controls set to keep hold their level through that second run.

Top module: `startup_seq`

## Requirements
- R1: A synchronous reset, active high, sets the phase to 0 and stops the sequence. It also sets DONE low, the 3-state hold high, the write enable low and the set-reset high.
- R2: The sequence begins on the first clock edge at which `startReq` is high. Nothing advances before that edge. While running, the phase rises by exactly one per edge unless a stall applies. It stops at 7.
- R3: A setting code from 0 to 6 picks a phase k. On the first edge at which the counter holds k while running, the control takes its active level, which is visible after that edge. The active levels are DONE high, 3-state low, write enable high and set-reset low. The control keeps that level until a reset or a rerun.
- R4: Code 8 on the 3-state, write-enable or set-reset setting makes that control take its active level on any running edge at which DONE-in is high. With pipelining off, DONE-in is the `donePin` level.
- R5: With `donePipeEn` high, DONE-in is `donePin` delayed by one clock. A code-8 event therefore lands one edge later than it would with pipelining off.
- R6: Code 9 on the 3-state, write-enable or set-reset setting leaves that control at its present level on every edge except reset, including the edge of a rerun.
- R7: If `lockCfg` equals the current phase (0 to 6) while running and `lockIn` is low, the phase holds and `stallLock` is high. Code 15 never stalls.
- R8: If `matchCfg` equals the current phase (0 to 6) while running and `matchIn` is low, the phase holds and `stallMatch` is high. Code 15 never stalls.
- R9: `startReq` high at phase 7 restarts the count at phase 0. On that edge every control not set to keep returns to its reset level. `startReq` while the phase is between 0 and 6 of a running sequence is ignored.
- R10: DONE follows only phase codes. Any `doneCfg` value of 7 or more leaves DONE low for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start or rerun request |
| doneCfg | input | 4 | DONE phase code |
| tsCfg | input | 4 | 3-state release code |
| weCfg | input | 4 | Write-enable code |
| srCfg | input | 4 | Set-reset release code |
| lockCfg | input | 4 | Lock stall phase, 15 = no wait |
| matchCfg | input | 4 | Match stall phase, 15 = no wait |
| donePipeEn | input | 1 | Delay DONE-in by one clock |
| donePin | input | 1 | Observed DONE pin level |
| lockIn | input | 1 | Clock-manager lock |
| matchIn | input | 1 | Impedance match done |
| doneOut | output | 1 | DONE drive |
| tristateOut | output | 1 | Global 3-state hold, high = held |
| writeEnOut | output | 1 | Global write enable, high = enabled |
| setResetOut | output | 1 | Global set-reset, high = asserted |
| phase | output | 3 | Current phase |
| stallLock | output | 1 | Stalled waiting for lock |
| stallMatch | output | 1 | Stalled waiting for match |

## Verification
The bench holds a lock stall and a match stall for several cycles, including a match stall at phase 0, which is the very first running phase. A counter that leaks past a stall, or that checks the wait before the sequence starts, shows the wrong phase during the hold. DONE-in events are driven with pipelining off and then on. A design that ignores the pipeline releases the control one cycle early. The rerun case sets one control to keep after it has already changed. A design that re-arms it, or that accepts a start request in the middle of a sequence, restores the 3-state hold or restarts the phase where it should not.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int PHASE_W = 3;
  localparam int CODE_W  = 4;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [PHASE_W-1:0] phase_t;

  localparam code_t CODE_DONEIN = 4'd8;
  localparam code_t CODE_KEEP   = 4'd9;
  localparam code_t CODE_NOWAIT = 4'd15;

  // Highest code that selects a phase: one below the finished phase.
  localparam code_t LAST_SEL = code_t'((1 << PHASE_W) - 2);

  typedef struct packed {
    logic   running;
    logic   rearm;
    phase_t phase;
  } seq_strobe_t;
endpackage

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import startup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  code_t       lockCfg,
  input  code_t       matchCfg,
  input  logic        lockIn,
  input  logic        matchIn,
  output seq_strobe_t strobes,
  output phase_t      phase,
  output logic        stallLock,
  output logic        stallMatch
);
  localparam phase_t LAST_PHASE = '1;

  logic   running;
  phase_t phaseQ;
  logic   finished;
  logic   go;
  logic   waitLock;
  logic   waitMatch;

  always_comb begin
    finished  = (phaseQ == LAST_PHASE);
    go        = startReq && (!running || finished);
    waitLock  = running && !finished && (lockCfg == code_t'(phaseQ)) && !lockIn;
    waitMatch = running && !finished && (matchCfg == code_t'(phaseQ)) && !matchIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phaseQ  <= '0;
    end else if (go) begin
      running <= 1'b1;
      phaseQ  <= '0;
    end else if (running && !finished && !waitLock && !waitMatch) begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  assign strobes    = '{running: running, rearm: go, phase: phaseQ};
  assign phase      = phaseQ;
  assign stallLock  = waitLock;
  assign stallMatch = waitMatch;
endmodule

// File: rtl/startup_evt.sv
module startup_evt
  import startup_pkg::*;
#(
  parameter logic RESET_VAL  = 1'b0,
  parameter bit   ALLOW_COND = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  seq_strobe_t strobes,
  input  code_t       cfg,
  input  logic        doneIn,
  output logic        level
);
  logic phaseHit;
  logic condHit;
  logic keepIt;

  always_comb begin
    phaseHit = (cfg <= LAST_SEL) && (cfg == code_t'(strobes.phase));
    condHit  = ALLOW_COND && (cfg == CODE_DONEIN) && doneIn;
    keepIt   = ALLOW_COND && (cfg == CODE_KEEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= RESET_VAL;
    end else if (keepIt) begin
      level <= level;
    end else if (strobes.rearm) begin
      level <= RESET_VAL;
    end else if (strobes.running && (phaseHit || condHit)) begin
      level <= ~RESET_VAL;
    end
  end
endmodule

// File: rtl/startup_dp.sv
module startup_dp
  import startup_pkg::*;
#(
  parameter int N_CTRL = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  seq_strobe_t strobes,
  input  code_t       doneCfg,
  input  code_t       tsCfg,
  input  code_t       weCfg,
  input  code_t       srCfg,
  input  logic        donePipeEn,
  input  logic        donePin,
  output logic        doneOut,
  output logic        tristateOut,
  output logic        writeEnOut,
  output logic        setResetOut
);
  // Index 0 DONE, 1 3-state, 2 write enable, 3 set-reset.
  localparam logic [N_CTRL-1:0] RST_VALS = 4'b1010;

  logic  pipeQ;
  logic  doneIn;
  code_t cfgArr [N_CTRL];
  logic [N_CTRL-1:0] levels;

  always_ff @(posedge clk) begin
    if (rst) pipeQ <= 1'b0;
    else     pipeQ <= donePin;
  end

  always_comb begin
    doneIn    = donePipeEn ? pipeQ : donePin;
    cfgArr[0] = doneCfg;
    cfgArr[1] = tsCfg;
    cfgArr[2] = weCfg;
    cfgArr[3] = srCfg;
  end

  for (genvar i = 0; i < N_CTRL; i++) begin : g_evt
    startup_evt #(
      .RESET_VAL (RST_VALS[i]),
      .ALLOW_COND(i != 0)
    ) u_evt (
      .clk    (clk),
      .rst    (rst),
      .strobes(strobes),
      .cfg    (cfgArr[i]),
      .doneIn (doneIn),
      .level  (levels[i])
    );
  end

  assign doneOut     = levels[0];
  assign tristateOut = levels[1];
  assign writeEnOut  = levels[2];
  assign setResetOut = levels[3];
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic [3:0] doneCfg,
  input  logic [3:0] tsCfg,
  input  logic [3:0] weCfg,
  input  logic [3:0] srCfg,
  input  logic [3:0] lockCfg,
  input  logic [3:0] matchCfg,
  input  logic       donePipeEn,
  input  logic       donePin,
  input  logic       lockIn,
  input  logic       matchIn,
  output logic       doneOut,
  output logic       tristateOut,
  output logic       writeEnOut,
  output logic       setResetOut,
  output logic [2:0] phase,
  output logic       stallLock,
  output logic       stallMatch
);
  seq_strobe_t strobes;

  startup_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .lockCfg   (lockCfg),
    .matchCfg  (matchCfg),
    .lockIn    (lockIn),
    .matchIn   (matchIn),
    .strobes   (strobes),
    .phase     (phase),
    .stallLock (stallLock),
    .stallMatch(stallMatch)
  );

  startup_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .doneCfg    (doneCfg),
    .tsCfg      (tsCfg),
    .weCfg      (weCfg),
    .srCfg      (srCfg),
    .donePipeEn (donePipeEn),
    .donePin    (donePin),
    .doneOut    (doneOut),
    .tristateOut(tristateOut),
    .writeEnOut (writeEnOut),
    .setResetOut(setResetOut)
  );
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       startReq,
  input logic [3:0] tsCfg,
  input logic [3:0] lockCfg,
  input logic [3:0] matchCfg,
  input logic       doneOut,
  input logic       tristateOut,
  input logic [2:0] phase,
  input logic       stallLock,
  input logic       stallMatch
);
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == $past(phase) + 3'd1 || phase == 3'd0)); // R2
  AST_PHASE_SAT: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd7 && !startReq) |=> (phase == 3'd7)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stallLock || stallMatch) |=> (phase == $past(phase))); // R7
  AST_NOWAIT_LOCK: assert property (@(posedge clk) disable iff (rst)
    (lockCfg == 4'd15) |-> !stallLock); // R7
  AST_NOWAIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (matchCfg == 4'd15) |-> !stallMatch); // R8
  AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tsCfg == 4'd9) |=> $stable(tristateOut)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !(startReq && phase == 3'd7)) |=> doneOut); // R3
endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .startReq   (startReq),
  .tsCfg      (tsCfg),
  .lockCfg    (lockCfg),
  .matchCfg   (matchCfg),
  .doneOut    (doneOut),
  .tristateOut(tristateOut),
  .phase      (phase),
  .stallLock  (stallLock),
  .stallMatch (stallMatch)
);

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic [3:0] doneCfg = 4'd4, tsCfg = 4'd5, weCfg = 4'd6, srCfg = 4'd6;
  logic [3:0] lockCfg = 4'd15, matchCfg = 4'd15;
  logic donePipeEn = 1'b0, donePin = 1'b0, lockIn = 1'b0, matchIn = 1'b0;
  logic doneOut, tristateOut, writeEnOut, setResetOut, stallLock, stallMatch;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  startup_seq u0 (
    .clk(clk), .rst(rst), .startReq(startReq),
    .doneCfg(doneCfg), .tsCfg(tsCfg), .weCfg(weCfg), .srCfg(srCfg),
    .lockCfg(lockCfg), .matchCfg(matchCfg),
    .donePipeEn(donePipeEn), .donePin(donePin), .lockIn(lockIn), .matchIn(matchIn),
    .doneOut(doneOut), .tristateOut(tristateOut), .writeEnOut(writeEnOut),
    .setResetOut(setResetOut), .phase(phase), .stallLock(stallLock), .stallMatch(stallMatch)
  );

  typedef struct {
    string      tag;
    logic [8:0] vec;  // phase, done, ts, we, sr, stallLock, stallMatch
  } exp_t;
  exp_t sb[$];

  // Expected-state tracker built from the requirements
  logic       mRun = 0, mD = 0, mT = 1, mW = 0, mS = 1, mP = 0;
  logic [2:0] mPh = 0;

  function automatic logic nxt(logic [3:0] c, logic cur, logic rv, bit cond, logic go, logic dIn);
    if (cond && c == 4'd9) return cur;               // R6 keep
    if (go) return rv;                               // R9 rerun
    if (mRun && ((c <= 4'd6 && c == {1'b0, mPh}) ||  // R3 phase
                 (cond && c == 4'd8 && dIn)))        // R4 DONE-in
      return ~rv;
    return cur;
  endfunction

  task automatic step(string tag);
    exp_t e;
    logic go, sL, sM, dIn;
    logic [2:0] nPh;
    if (rst) begin
      mRun = 0; mPh = 0; mD = 0; mT = 1; mW = 0; mS = 1; mP = 0;
    end else begin
      dIn = donePipeEn ? mP : donePin;
      go  = startReq && (!mRun || mPh == 3'd7);
      sL  = mRun && mPh != 3'd7 && lockCfg == {1'b0, mPh} && !lockIn;
      sM  = mRun && mPh != 3'd7 && matchCfg == {1'b0, mPh} && !matchIn;
      nPh = go ? 3'd0 : ((mRun && mPh != 3'd7 && !sL && !sM) ? mPh + 3'd1 : mPh);
      mD  = nxt(doneCfg, mD, 1'b0, 1'b0, go, dIn);
      mT  = nxt(tsCfg,   mT, 1'b1, 1'b1, go, dIn);
      mW  = nxt(weCfg,   mW, 1'b0, 1'b1, go, dIn);
      mS  = nxt(srCfg,   mS, 1'b1, 1'b1, go, dIn);
      mP  = donePin;
      mRun = mRun | go;
      mPh = nPh;
    end
    sL = mRun && mPh != 3'd7 && lockCfg == {1'b0, mPh} && !lockIn;
    sM = mRun && mPh != 3'd7 && matchCfg == {1'b0, mPh} && !matchIn;
    e.tag = tag;
    e.vec = {mPh, mD, mT, mW, mS, sL, sM};
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic steps(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic [8:0] act;
        e = sb.pop_front();
        act = {phase, doneOut, tristateOut, writeEnOut, setResetOut, stallLock, stallMatch};
        checks++;
        if (act !== e.vec) begin
          errors++;
          $display("FAIL %s: actual %b expected %b (phase,done,ts,we,sr,stL,stM)", e.tag, act, e.vec);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; startReq = 1'b0;
    steps("R1", 2);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // Reset state and idle without a start request
    do_reset();
    steps("R2", 3);

    // Phase-driven events with typical settings
    startReq = 1'b1; step("R2");
    startReq = 1'b0; steps("R3", 10);

    // Rerun with the 3-state control kept; mid-sequence start ignored
    tsCfg = 4'd9;
    startReq = 1'b1; step("R6");
    startReq = 1'b0; steps("R6", 3);
    startReq = 1'b1; step("R9");
    startReq = 1'b0; steps("R9", 8);
    tsCfg = 4'd5;
    startReq = 1'b1; step("R9");
    startReq = 1'b0; steps("R9", 9);

    // Lock stall at phase 2
    do_reset();
    lockCfg = 4'd2; lockIn = 1'b0; tsCfg = 4'd1;
    startReq = 1'b1; step("R7");
    startReq = 1'b0; steps("R7", 6);
    lockIn = 1'b1; steps("R7", 8);
    lockCfg = 4'd15;

    // Match stall at phase 0
    do_reset();
    matchCfg = 4'd0; matchIn = 1'b0;
    startReq = 1'b1; step("R8");
    startReq = 1'b0; steps("R8", 4);
    matchIn = 1'b1; steps("R8", 9);
    matchCfg = 4'd15;

    // DONE-in events, pipelining off
    do_reset();
    tsCfg = 4'd8; weCfg = 4'd8; srCfg = 4'd6; doneCfg = 4'd3; donePipeEn = 1'b0; donePin = 1'b0;
    startReq = 1'b1; step("R4");
    startReq = 1'b0; steps("R4", 5);
    donePin = 1'b1; steps("R4", 4);

    // DONE-in events, pipelining on
    donePin = 1'b0;
    do_reset();
    donePipeEn = 1'b1;
    startReq = 1'b1; step("R5");
    startReq = 1'b0; steps("R5", 5);
    donePin = 1'b1; steps("R5", 4);
    donePin = 1'b0; donePipeEn = 1'b0;

    // DONE ignores non-phase codes
    do_reset();
    doneCfg = 4'd8; tsCfg = 4'd2; weCfg = 4'd6;
    startReq = 1'b1; step("R10");
    startReq = 1'b0; steps("R10", 9);
    doneCfg = 4'd7;
    startReq = 1'b1; step("R10");
    startReq = 1'b0; steps("R10", 9);

    @(negedge clk);
    @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule